// File: doc/BRIEF.md
# Heartbeat Watchdog with Request/Acknowledge Handshake

This block supervises one signal processor. It sits disarmed after reset and does nothing until the processor writes its watchdog entry for the first time. From then on it runs a loop. It raises a heartbeat request toward a shared register-file arbiter and holds it until the arbiter grants it. It then waits for the processor's "updated" acknowledgement. After a short pause it issues the next request.

A timeout counter supervises each request. It clears when the request is issued and counts every cycle until the acknowledgement, including the time spent waiting for the grant. If the counter reaches its last value with no acknowledgement, the processor is declared dead. The block then raises a level dead flag that stays high, and a one-cycle reset request for the reset controller. Only a synchronous reset clears the dead state and disarms the block.

Top module: `hb_watchdog`

## Requirements
- R1: While `rst` is high and after it is released, `dead`, `rst_ask` and `req` are 0, and `req` stays 0 for as long as `cpu_wr` has not been seen high.
- R2: A `cpu_wr` pulse while disarmed makes `req` go high after the edge that samples it. `cpu_wr` pulses after arming change neither the pause length nor the request timing.
- R3: `req` stays high until an edge samples `gnt` high and goes low after that edge. An `upd_ack` seen while the request is still ungranted is ignored.
- R4: When an edge accepts `upd_ack` after the grant, `req` goes low. It rises again exactly GAP_CYC clock edges later.
- R5: The timeout counter clears when a request is issued, and the time spent waiting for the grant counts against it. An `upd_ack` sampled at the 2^TMO_W-th edge after the issuing edge is still accepted (16 with TMO_W=4).
- R6: If no acknowledgement has been accepted by that edge, `dead` goes high after it. In the same cycle `rst_ask` is high, and it is high for that one cycle only.
- R7: While `dead` is high, `req` is 0.
- R8: `dead` stays high until `rst`. `cpu_wr`, `gnt` and `upd_ack` have no effect on it, and no further `rst_ask` pulse occurs.
- R9: `rst` is synchronous. It clears `dead` and returns the block to the disarmed state, from which R1 and R2 apply again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | Processor wrote the watchdog entry (arms the block) |
| req | output | 1 | Heartbeat request toward the register-file arbiter |
| gnt | input | 1 | Arbiter grant for `req` |
| upd_ack | input | 1 | "Updated" acknowledgement from the processor side |
| dead | output | 1 | Processor declared dead (level, sticky) |
| rst_ask | output | 1 | One-cycle request to reset the processor |

## Verification
The acknowledgement and the timeout overflow can land on the same clock edge. The rule is that the acknowledgement wins on the last counted edge and loses one edge later. The bench provokes this with two handshakes. Both are granted at once. In the first, the acknowledgement is placed exactly on the 16th edge after the request, and the bench judges it by `dead` staying low and the next request appearing after the normal pause. In the second, the acknowledgement is one edge too late, and the bench judges it by `dead` rising with a single-cycle `rst_ask` and the late acknowledgement changing nothing.

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int TMO_W   = 4,
  parameter int GAP_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_wr,
  output logic req,
  input  logic gnt,
  input  logic upd_ack,
  output logic dead,
  output logic rst_ask
);
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [TMO_W-1:0] TMO_LAST = '1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

  typedef enum logic [2:0] {S_OFF, S_GAP, S_REQ, S_WAIT, S_DEAD} st_t;

  st_t              st;
  logic [TMO_W-1:0] tmo;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_OFF;
      tmo     <= '0;
      gap     <= '0;
      rst_ask <= 1'b0;
    end else begin
      rst_ask <= 1'b0;
      case (st)
        S_OFF: if (cpu_wr) begin
          st  <= S_REQ;
          tmo <= '0;
        end
        S_GAP: if (gap == GAP_LAST) begin
          st  <= S_REQ;
          tmo <= '0;
        end else begin
          gap <= gap + 1'b1;
        end
        S_REQ, S_WAIT: begin
          if (st == S_WAIT && upd_ack) begin
            st  <= S_GAP;
            gap <= '0;
          end else if (tmo == TMO_LAST) begin
            st      <= S_DEAD;
            rst_ask <= 1'b1;
          end else begin
            tmo <= tmo + 1'b1;
            if (st == S_REQ && gnt) st <= S_WAIT;
          end
        end
        default: st <= S_DEAD;
      endcase
    end
  end

  assign req  = (st == S_REQ);
  assign dead = (st == S_DEAD);
endmodule

module hb_watchdog_chk (
  input logic clk,
  input logic rst,
  input logic cpu_wr,
  input logic req,
  input logic gnt,
  input logic dead,
  input logic rst_ask
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else if (cpu_wr) seen <= 1'b1;
  end

  assert_dormant_R1: assert property (@(posedge clk) disable iff (rst) !seen |-> !req);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst) (req && !gnt) |=> (req || dead));
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst) rst_ask |=> !rst_ask);
  assert_pulse_with_dead_R6: assert property (@(posedge clk) disable iff (rst) rst_ask |-> dead);
  assert_no_req_dead_R7: assert property (@(posedge clk) disable iff (rst) dead |-> !req);
  assert_dead_sticky_R8: assert property (@(posedge clk) disable iff (rst) dead |=> dead);
endmodule

bind hb_watchdog hb_watchdog_chk chk (
  .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .req(req),
  .gnt(gnt), .dead(dead), .rst_ask(rst_ask)
);

// File: tb/hb_watchdog_test.sv
`timescale 1ns/1ps
module hb_watchdog_test;
  logic clk = 1'b0, rst = 1'b1, cpu_wr = 1'b0, gnt = 1'b0, upd_ack = 1'b0;
  logic req, dead, rst_ask;
  int checks = 0, errors = 0;
  bit done = 0;

  hb_watchdog #(.TMO_W(4), .GAP_CYC(3)) uut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .req(req), .gnt(gnt),
    .upd_ack(upd_ack), .dead(dead), .rst_ask(rst_ask)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {req,dead,rst_ask} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cpu_wr = 0; gnt = 0; upd_ack = 0;
    tick(); tick();
    chk("R9 outputs during reset", {req, dead, rst_ask}, 3'b000);
    rst = 1'b0;
  endtask

  task automatic test_dormant();
    for (int i = 0; i < 40; i++) begin
      if (i == 5) begin gnt = 1; upd_ack = 1; end
      tick();
    end
    gnt = 0; upd_ack = 0;
    chk("R1 no request before first processor write", {req, dead, rst_ask}, 3'b000);
  endtask

  task automatic arm();
    cpu_wr = 1; tick(); cpu_wr = 0;
    chk("R2 request after first write", {req, dead, rst_ask}, 3'b100);
  endtask

  task automatic gap_then_req(string tag);
    chk({tag, " req low after ack"}, {req, dead, rst_ask}, 3'b000);
    cpu_wr = 1; tick(); cpu_wr = 0;
    chk("R2 write while armed keeps pause", {req, dead, rst_ask}, 3'b000);
    tick();
    chk({tag, " still pausing"}, {req, dead, rst_ask}, 3'b000);
    tick();
    chk({tag, " next request after pause"}, {req, dead, rst_ask}, 3'b100);
  endtask

  task automatic test_handshake();
    for (int i = 0; i < 3; i++) begin
      if (i == 1) upd_ack = 1;
      tick();
      upd_ack = 0;
    end
    chk("R3 req held and early ack ignored", {req, dead, rst_ask}, 3'b100);
    gnt = 1; tick(); gnt = 0;
    chk("R3 req drops after grant", {req, dead, rst_ask}, 3'b000);
    upd_ack = 1; tick(); upd_ack = 0;
    gap_then_req("R4");
  endtask

  task automatic test_boundary_ok();
    gnt = 1; tick(); gnt = 0;
    for (int i = 0; i < 14; i++) tick();
    chk("R5 waiting near limit", {req, dead, rst_ask}, 3'b000);
    upd_ack = 1; tick(); upd_ack = 0;
    gap_then_req("R5 ack on last edge");
  endtask

  task automatic test_late_ack();
    gnt = 1; tick(); gnt = 0;
    for (int i = 0; i < 14; i++) tick();
    chk("R6 alive one edge before overflow", {req, dead, rst_ask}, 3'b000);
    tick();
    chk("R6 dead with reset pulse", {req, dead, rst_ask}, 3'b011);
    upd_ack = 1; tick(); upd_ack = 0;
    chk("R6 pulse single cycle, late ack ignored", {req, dead, rst_ask}, 3'b010);
    cpu_wr = 1; gnt = 1; tick(); cpu_wr = 0; gnt = 0;
    tick(); tick();
    chk("R8 dead sticky, R7 no request", {req, dead, rst_ask}, 3'b010);
  endtask

  task automatic test_no_grant();
    for (int i = 0; i < 15; i++) tick();
    chk("R5 grant wait counts toward timeout", {req, dead, rst_ask}, 3'b100);
    tick();
    chk("R6 timeout without grant", {req, dead, rst_ask}, 3'b011);
    tick();
    chk("R7 request withdrawn when dead", {req, dead, rst_ask}, 3'b010);
  endtask

  initial begin
    do_reset();
    chk("R1 after reset", {req, dead, rst_ask}, 3'b000);
    test_dormant();
    arm();
    test_handshake();
    test_boundary_ok();
    test_late_ack();
    do_reset();
    tick();
    chk("R9 reset clears dead", {req, dead, rst_ask}, 3'b000);
    test_dormant();
    arm();
    test_no_grant();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule